// File: doc/BRIEF.md
# Open-Drain Arbitration Loss Monitor

This block watches a software-driven two-wire bus transmitter that shares its lines with other masters. The transmitter states, bit by bit, the level it wants on the data line and on the clock line. The block turns each wish into an output-enable for a pull-down driver whose level is fixed low. A wanted 1 leaves the line released, so the pull-up sets it. A wanted 0 turns the driver on.

The raw bus levels are brought into the clock domain through a synchronizer. While the clock line is high, the data line is sampled once, a fixed number of cycles into the high phase. If the transmitter had released the data line but the sample reads low, another master has won the bus. The block then drops both drivers and raises a sticky loss flag. The flag records whether the loss fell in the address byte, which is the first byte after a Start, or in a later data byte. A loss in a data byte also raises a retry request. The acknowledge slot that follows every byte is never compared.

Top module: `arb_loss_monitor`

## Requirements
- R1: `sda_oe` is 1 exactly when `sda_tx` is 0 and no loss is flagged. `scl_oe` is 1 exactly when `scl_tx` is 0 and no loss is flagged. Both follow their inputs in the same cycle.
- R2: After reset, `arb_lost`, `lost_in_addr` and `retry_req` are 0.
- R3: The data line is compared once per clock-line high phase. When `scl_in` rises before rising edge 1, the comparison result is visible after edge SAMPLE_DLY+3, which is edge 6 at the default SAMPLE_DLY=3, and not after edge SAMPLE_DLY+2.
- R4: A bit that is sent as 0 (`sda_tx`=0) never causes a loss, whatever level the bus shows.
- R5: The acknowledge slot is never compared. This slot is the ninth sampled bit of each byte, counted from a Start.
- R6: Once a loss is flagged, `sda_oe` and `scl_oe` stay 0 whatever `sda_tx` and `scl_tx` request.
- R7: A loss in the first byte after a Start gives `lost_in_addr`=1 and `retry_req`=0. A loss in any later byte gives `lost_in_addr`=0 and `retry_req`=1.
- R8: The loss flag and its stage stay set until `clear_loss` is pulsed, and the pulse clears all three flags. While the flag is set, no comparison takes place, so the recorded stage does not change.
- R9: If `clear_loss` arrives in the same cycle as a comparison that detects a new loss, the new loss wins. The flag ends set, with the stage of the new event.
- R10: A low on the data line while the clock line is low does not count as a loss, provided the line is back high before the sample point.
- R11: A `start_mark` pulse restarts the bit count in the address stage. The clock-line high phase that contains the pulse is not counted as a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw clock-line level read from the bus |
| sda_in | input | 1 | Raw data-line level read from the bus |
| scl_tx | input | 1 | Wanted clock-line level (1 = release) |
| sda_tx | input | 1 | Wanted data-line level (1 = release) |
| start_mark | input | 1 | One-cycle pulse when the transmitter issues a Start |
| clear_loss | input | 1 | One-cycle pulse that clears the loss flags |
| scl_oe | output | 1 | Enable of the low driver on the clock line |
| sda_oe | output | 1 | Enable of the low driver on the data line |
| arb_lost | output | 1 | Sticky arbitration-loss flag |
| lost_in_addr | output | 1 | Loss happened in the address byte |
| retry_req | output | 1 | Loss happened in a data byte, so the transfer must be resent |

## Verification
Two functions can fall in the same cycle: software clearing the loss flag, and the sampler detecting a fresh loss. The bench provokes this by raising the clock line and then counting edges through the synchronizer and the sample timer. It pulses `clear_loss` so that the pulse is registered on the very edge that latches the mismatch. The bench judges the result at the ports: the flag must still be set, it must carry the address stage of the new event, and both drivers must stay released.

// File: rtl/arb_mon_pkg.sv
package arb_mon_pkg;

    typedef enum logic {
        STG_ADDR = 1'b0,
        STG_DATA = 1'b1
    } stage_e;

    typedef struct packed {
        logic   lost;
        stage_e stage;
    } loss_state_s;

endpackage

// File: rtl/arbmon_sync.sv
module arbmon_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (g == 0) begin : g_first
            always_comb stage_d = raw_i;
        end else begin : g_next
            always_comb stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '1;
            else        stage_q[g] <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/arbmon_sample_timer.sv
module arbmon_sample_timer #(
    parameter int SAMPLE_DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    output logic sample_pulse
);
    localparam int CNT_W = $clog2(SAMPLE_DLY + 2);
    localparam logic [CNT_W-1:0] DLY_V = CNT_W'(SAMPLE_DLY);
    localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAMPLE_DLY + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!scl_s)              cnt_d = '0;
        else if (cnt_q != SAT_V) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign sample_pulse = scl_s && (cnt_q == DLY_V);

    assert_single_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pulse |=> !sample_pulse);

    assert_sample_needs_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pulse |-> $past(scl_s));
endmodule

// File: rtl/arbmon_bit_tracker.sv
module arbmon_bit_tracker
    import arb_mon_pkg::*;
#(
    parameter int BITS_PER_BYTE = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   scl_s,
    input  logic   sample_pulse,
    input  logic   start_mark,
    output logic   bit_strobe,
    output logic   ack_slot,
    output stage_e stage
);
    localparam int IDX_W = $clog2(BITS_PER_BYTE + 1);
    localparam logic [IDX_W-1:0] ACK_IDX = IDX_W'(BITS_PER_BYTE);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        stage_e           stage;
        logic             skip;
    } trk_s;

    trk_s trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (!scl_s) trk_d.skip = 1'b0;
        if (start_mark) begin
            trk_d.idx   = '0;
            trk_d.stage = STG_ADDR;
            trk_d.skip  = 1'b1;
        end else if (sample_pulse && !trk_q.skip) begin
            if (trk_q.idx == ACK_IDX) begin
                trk_d.idx   = '0;
                trk_d.stage = STG_DATA;
            end else begin
                trk_d.idx = trk_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '{idx: '0, stage: STG_ADDR, skip: 1'b0};
        else        trk_q <= trk_d;
    end

    assign bit_strobe = sample_pulse && !trk_q.skip && !start_mark;
    assign ack_slot   = (trk_q.idx == ACK_IDX);
    assign stage      = trk_q.stage;

    assert_index_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.idx <= ACK_IDX);

    assert_data_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_strobe && ack_slot) |=> (stage == STG_DATA));

    assert_start_restarts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_mark |=> (stage == STG_ADDR && trk_q.idx == '0));
endmodule

// File: rtl/arb_loss_monitor.sv
module arb_loss_monitor
    import arb_mon_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int SAMPLE_DLY    = 3,
    parameter int BITS_PER_BYTE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic scl_tx,
    input  logic sda_tx,
    input  logic start_mark,
    input  logic clear_loss,
    output logic scl_oe,
    output logic sda_oe,
    output logic arb_lost,
    output logic lost_in_addr,
    output logic retry_req
);
    logic [1:0] bus_s;
    logic       scl_s, sda_s;
    logic       sample_pulse, bit_strobe, ack_slot;
    stage_e     cur_stage;

    arbmon_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i({scl_in, sda_in}), .sync_o(bus_s));
    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];

    arbmon_sample_timer #(.SAMPLE_DLY(SAMPLE_DLY)) u_timer (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sample_pulse(sample_pulse));

    arbmon_bit_tracker #(.BITS_PER_BYTE(BITS_PER_BYTE)) u_track (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sample_pulse(sample_pulse),
        .start_mark(start_mark), .bit_strobe(bit_strobe), .ack_slot(ack_slot),
        .stage(cur_stage));

    loss_state_s st_d, st_q;
    logic        mismatch;

    always_comb begin
        mismatch = !st_q.lost && bit_strobe && !ack_slot && sda_tx && !sda_s;
        st_d = st_q;
        if (clear_loss) st_d.lost = 1'b0;
        if (mismatch) begin
            st_d.lost  = 1'b1;
            st_d.stage = cur_stage;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lost: 1'b0, stage: STG_ADDR};
        else        st_q <= st_d;
    end

    assign sda_oe       = !st_q.lost && !sda_tx;
    assign scl_oe       = !st_q.lost && !scl_tx;
    assign arb_lost     = st_q.lost;
    assign lost_in_addr = st_q.lost && (st_q.stage == STG_ADDR);
    assign retry_req    = st_q.lost && (st_q.stage == STG_DATA);

    assert_sticky_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && !clear_loss) |=> arb_lost);

    assert_stage_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && !clear_loss) |=> $stable(retry_req));

    assert_one_stage_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> (lost_in_addr ^ retry_req));

    assert_loss_needs_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> $past(sda_tx));

    assert_loss_needs_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> $past(sample_pulse));
endmodule

// File: tb/tb_arb_loss_monitor.sv
module tb_arb_loss_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_scl = 1'b1, bus_sda = 1'b1;
    logic scl_tx = 1'b1, sda_tx = 1'b1;
    logic start_mark = 1'b0, clear_loss = 1'b0;
    logic scl_oe, sda_oe, arb_lost, lost_in_addr, retry_req;
    int   n_checks = 0;
    int   n_fails  = 0;

    always #5 clk = ~clk;

    arb_loss_monitor dut (
        .clk(clk), .rst_n(rst_n), .scl_in(bus_scl), .sda_in(bus_sda),
        .scl_tx(scl_tx), .sda_tx(sda_tx), .start_mark(start_mark),
        .clear_loss(clear_loss), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .arb_lost(arb_lost), .lost_in_addr(lost_in_addr), .retry_req(retry_req));

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic chk_flags(input string req, input logic l, input logic a, input logic r);
        chk({req, " lost"}, arb_lost, l);
        chk({req, " addr"}, lost_in_addr, a);
        chk({req, " retry"}, retry_req, r);
    endtask

    task automatic send_bit(input logic tx, input logic bus);
        @(negedge clk);
        bus_scl = 1'b0; scl_tx = 1'b0; sda_tx = tx; bus_sda = bus;
        repeat (4) @(negedge clk);
        bus_scl = 1'b1; scl_tx = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic do_start();
        @(negedge clk);
        bus_scl = 1'b0; scl_tx = 1'b0; sda_tx = 1'b1; bus_sda = 1'b1;
        repeat (4) @(negedge clk);
        bus_scl = 1'b1; scl_tx = 1'b1;
        repeat (8) @(negedge clk);
        sda_tx = 1'b0; bus_sda = 1'b0; start_mark = 1'b1;
        @(negedge clk);
        start_mark = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk); clear_loss = 1'b1;
        @(negedge clk); clear_loss = 1'b0;
    endtask

    task automatic t_reset();
        sda_tx = 1'b0; scl_tx = 1'b1;
        #1;
        chk_flags("R2", 1'b0, 1'b0, 1'b0);
        chk("R1 sda_oe low wanted", sda_oe, 1'b1);
        chk("R1 scl_oe released", scl_oe, 1'b0);
        sda_tx = 1'b1; scl_tx = 1'b0;
        #1;
        chk("R1 sda_oe released", sda_oe, 1'b0);
        chk("R1 scl_oe low wanted", scl_oe, 1'b1);
        scl_tx = 1'b1;
    endtask

    task automatic t_addr_loss();
        do_start();
        send_bit(1'b1, 1'b1);
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b1);
        chk("R4 no loss on matching bits", arb_lost, 1'b0);
        @(negedge clk);
        bus_scl = 1'b0; scl_tx = 1'b0; sda_tx = 1'b1; bus_sda = 1'b0;
        repeat (4) @(negedge clk);
        bus_scl = 1'b1; scl_tx = 1'b1;
        repeat (5) @(negedge clk);
        chk("R3 not yet at edge 5", arb_lost, 1'b0);
        @(negedge clk);
        chk("R3 seen at edge 6", arb_lost, 1'b1);
        chk_flags("R7 address stage", 1'b1, 1'b1, 1'b0);
        sda_tx = 1'b0; scl_tx = 1'b0;
        #1;
        chk("R6 sda released", sda_oe, 1'b0);
        chk("R6 scl released", scl_oe, 1'b0);
        scl_tx = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 sticky", arb_lost, 1'b1);
        pulse_clear();
        chk_flags("R8 cleared", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_zero_and_glitch();
        do_start();
        send_bit(1'b0, 1'b0);
        chk("R4 zero sent, bus low", arb_lost, 1'b0);
        @(negedge clk);
        bus_scl = 1'b0; scl_tx = 1'b0; sda_tx = 1'b1; bus_sda = 1'b0;
        repeat (2) @(negedge clk);
        bus_sda = 1'b1;
        repeat (3) @(negedge clk);
        bus_scl = 1'b1; scl_tx = 1'b1;
        repeat (8) @(negedge clk);
        chk("R10 low-phase glitch ignored", arb_lost, 1'b0);
    endtask

    task automatic t_ack_and_data();
        do_start();
        for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b1);
        send_bit(1'b1, 1'b0);
        chk("R5 ack slot not compared", arb_lost, 1'b0);
        send_bit(1'b1, 1'b0);
        chk_flags("R7 data stage", 1'b1, 1'b0, 1'b1);
        send_bit(1'b1, 1'b0);
        chk_flags("R8 stage frozen while lost", 1'b1, 1'b0, 1'b1);
        pulse_clear();
        chk_flags("R8 cleared after data loss", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_clear_collision();
        do_start();
        @(negedge clk);
        bus_scl = 1'b0; scl_tx = 1'b0; sda_tx = 1'b1; bus_sda = 1'b0;
        repeat (4) @(negedge clk);
        bus_scl = 1'b1; scl_tx = 1'b1;
        repeat (5) @(negedge clk);
        clear_loss = 1'b1;
        @(negedge clk);
        clear_loss = 1'b0;
        chk_flags("R9 new loss beats clear", 1'b1, 1'b1, 1'b0);
        sda_tx = 1'b0;
        #1;
        chk("R9 drivers stay released", sda_oe, 1'b0);
        pulse_clear();
        chk("R9 later clear works", arb_lost, 1'b0);
    endtask

    task automatic t_restart();
        do_start();
        for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b1);
        do_start();
        for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b1);
        send_bit(1'b1, 1'b0);
        chk("R11 ack slot recounted from new start", arb_lost, 1'b0);
        do_start();
        send_bit(1'b1, 1'b0);
        chk_flags("R11 new start is address stage", 1'b1, 1'b1, 1'b0);
        pulse_clear();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_addr_loss();
        t_zero_and_glitch();
        t_ack_and_data();
        t_clear_collision();
        t_restart();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule